// File: doc/BRIEF.md
# UART Boot Code Loader

This block fills an on-chip instruction memory with a program image. A host sends the image as raw bytes on a serial receive line. The block recovers each byte, queues it in a small FIFO, and packs every four bytes into a 32-bit word. It writes those words through a single write port to word addresses 0, 1, 2 and onward. The FIFO means the memory write side never has to follow the timing of the serial line.

Loading ends in one of two ways: a programmed number of words has been written, or the line has been silent for a set number of clocks after the first byte. If a final word has fewer than four bytes, it is padded with zeros and written. The block then stops the clock of its own logic through a glitch-free latch gate. On the next free-running clock edge it raises a handover output. That output switches the memory port to the processor bus for good and lets the core start from address 0. If a byte is lost to a full FIFO, an error flag is raised and held, and handover never happens.

Top module: `bootld_top`

## Requirements
- R1: After reset, handover and load_err are 0, mem_we is 0 and mem_addr is 0, whatever the cpu_* inputs carry.
- R2: The serial line is decoded as 8N1 (idle high, one low start bit, 8 data bits least significant first, one high stop bit) at BAUD bits per second. Each bit is sampled at its middle using 16 oversampling ticks of CLK_HZ/(16*BAUD) clocks.
- R3: A low pulse on rxd that is high again at the middle of the start bit (8 ticks after the falling edge) yields no byte.
- R4: Four bytes received in a row form one word little-endian: the first byte is bits 7:0, the second 15:8, the third 23:16 and the fourth 31:24.
- R5: Words are written to word addresses 0, 1, 2 and so on with no gaps. mem_we is high for exactly one clock per word.
- R6: When cfg_words is not zero, writing word number cfg_words ends the load. handover then rises a few clocks later and no further loader write follows.
- R7: Once at least one byte has arrived, the load ends after TIMEOUT_CYC clocks with no new byte and the FIFO empty. A partial word is written first, with its missing upper bytes set to zero. Before the first byte no timeout runs.
- R8: handover stays high until reset. While it is high, mem_addr, mem_wdata and mem_we equal cpu_addr, cpu_wdata and cpu_we, and bytes on rxd cause no memory write.
- R9: A byte that arrives while the FIFO is full sets load_err. load_err stays set until reset, and handover is never asserted.
- R10: With cfg_words equal to 0, only the timeout ends the load (or a completely filled memory).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_words | input | ADDR_W+1 | Number of words that ends the load; 0 selects timeout only |
| cpu_addr | input | ADDR_W | Processor bus word address |
| cpu_wdata | input | 32 | Processor bus write data |
| cpu_we | input | 1 | Processor bus write strobe |
| mem_addr | output | ADDR_W | Instruction memory word address |
| mem_wdata | output | 32 | Instruction memory write data |
| mem_we | output | 1 | Instruction memory write strobe |
| handover | output | 1 | Memory owned by the processor and core released |
| load_err | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench builds the main instance with CLK_HZ and BAUD chosen so that one oversampling tick is 4 clocks and one bit is 64 clocks. It uses TIMEOUT_CYC of 3000 and an 8-bit address, so that many complete byte frames and several timeout windows fit into a short run. A second instance has a 2-entry FIFO and POP_GAP of 4000. That setting makes the FIFO drain slower than bytes arrive, so overflow and the withheld handover can be reached at all.

// File: rtl/bootld_pkg.sv
package bootld_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

endpackage

// File: rtl/bootld_rx.sv
module bootld_rx #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  output logic [7:0] rx_byte,
  output logic       rx_vld
);
  import bootld_pkg::*;

  localparam int DIV_RAW = CLK_HZ / (BAUD * 16);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int DIV_W   = $clog2(DIV + 1);

  logic             sync1_q, sync2_q;
  logic [DIV_W-1:0] div_q, div_d;
  logic             tick;
  rx_state_t        st_q, st_d;
  logic [3:0]       os_q, os_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             vld_q, vld_d;

  assign tick = (div_q == DIV_W'(DIV - 1));

  always_comb begin
    div_d = tick ? '0 : div_q + 1'b1;
    st_d  = st_q;
    os_d  = os_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (!sync2_q) begin
          st_d  = RX_START;
          os_d  = '0;
          div_d = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (os_q == 4'd7) begin
            os_d  = '0;
            bit_d = '0;
            st_d  = sync2_q ? RX_IDLE : RX_DATA;
          end else begin
            os_d = os_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (os_q == 4'd15) begin
            os_d  = '0;
            sh_d  = {sync2_q, sh_q[7:1]};
            bit_d = bit_q + 1'b1;
            if (bit_q == 3'd7) st_d = RX_STOP;
          end else begin
            os_d = os_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (os_q == 4'd15) begin
            st_d  = RX_IDLE;
            vld_d = sync2_q;
          end else begin
            os_d = os_q + 1'b1;
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      div_q   <= '0;
      st_q    <= RX_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      vld_q   <= 1'b0;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
      div_q   <= div_d;
      st_q    <= st_d;
      os_q    <= os_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      vld_q   <= vld_d;
    end
  end

  assign rx_byte = sh_q;
  assign rx_vld  = vld_q;

endmodule

// File: rtl/bootld_fifo.sv
module bootld_fifo #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] din,
  input  logic       pop,
  output logic [7:0] dout,
  output logic       empty,
  output logic       ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0]       store_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             full, do_wr, do_rd;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q | (push && full);
    if (do_wr) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_rd) rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) store_q[wr_q] <= din;
  end

  assign dout = store_q[rd_q];
  assign ovf  = ovf_q;

endmodule

// File: rtl/bootld_seq.sv
module bootld_seq #(
  parameter int ADDR_W      = 14,
  parameter int TIMEOUT_CYC = 5_000_000,
  parameter int POP_GAP     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic [7:0]        fifo_byte,
  input  logic              rx_seen,
  input  logic [ADDR_W:0]   cfg_words,
  output logic              fifo_pop,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              done
);
  localparam int IDLE_W = $clog2(TIMEOUT_CYC + 1);
  localparam int GAP_W  = $clog2(POP_GAP + 2);
  localparam logic [ADDR_W:0] MEM_WORDS = (ADDR_W+1)'(1) << ADDR_W;

  logic [31:0]       acc_q, acc_d;
  logic [1:0]        lane_q, lane_d;
  logic [ADDR_W:0]   wcnt_q, wcnt_d, wnext;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [31:0]       wd_q, wd_d;
  logic              last_q, last_d, done_q, done_d;
  logic              armed_q, armed_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              pop, timeout;

  assign wnext   = wcnt_q + 1'b1;
  assign pop     = !fifo_empty && (gap_q == '0) && !last_q && !done_q;
  assign timeout = armed_q && fifo_empty && !last_q && !done_q &&
                   (idle_q == IDLE_W'(TIMEOUT_CYC - 1));

  always_comb begin
    acc_d   = acc_q;
    lane_d  = lane_q;
    wcnt_d  = wcnt_q;
    wr_d    = 1'b0;
    wa_d    = wa_q;
    wd_d    = wd_q;
    last_d  = last_q;
    done_d  = done_q | last_q;
    armed_d = armed_q | rx_seen;
    idle_d  = idle_q;
    gap_d   = gap_q;
    if (rx_seen) idle_d = '0;
    else if (armed_q && idle_q != IDLE_W'(TIMEOUT_CYC - 1)) idle_d = idle_q + 1'b1;
    if (pop) gap_d = GAP_W'(POP_GAP);
    else if (gap_q != '0) gap_d = gap_q - 1'b1;
    if (pop) begin
      if (lane_q == 2'd3) begin
        wr_d   = 1'b1;
        wd_d   = acc_q | {fifo_byte, 24'h0};
        wa_d   = wcnt_q[ADDR_W-1:0];
        wcnt_d = wnext;
        acc_d  = '0;
        lane_d = '0;
        last_d = (wnext == cfg_words) || (wnext == MEM_WORDS);
      end else begin
        acc_d[{lane_q, 3'b000} +: 8] = fifo_byte;
        lane_d = lane_q + 1'b1;
      end
    end else if (timeout) begin
      if (lane_q != 2'd0) begin
        wr_d   = 1'b1;
        wd_d   = acc_q;
        wa_d   = wcnt_q[ADDR_W-1:0];
        wcnt_d = wnext;
      end
      last_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      lane_q  <= '0;
      wcnt_q  <= '0;
      wr_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
      idle_q  <= '0;
      gap_q   <= '0;
    end else begin
      acc_q   <= acc_d;
      lane_q  <= lane_d;
      wcnt_q  <= wcnt_d;
      wr_q    <= wr_d;
      wa_q    <= wa_d;
      wd_q    <= wd_d;
      last_q  <= last_d;
      done_q  <= done_d;
      armed_q <= armed_d;
      idle_q  <= idle_d;
      gap_q   <= gap_d;
    end
  end

  assign fifo_pop = pop;
  assign wr_en    = wr_q;
  assign wr_addr  = wa_q;
  assign wr_data  = wd_q;
  assign done     = done_q;

endmodule

// File: rtl/bootld_top.sv
module bootld_top #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BAUD        = 115_200,
  parameter int FIFO_DEPTH  = 8,
  parameter int ADDR_W      = 14,
  parameter int TIMEOUT_CYC = 5_000_000,
  parameter int POP_GAP     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [ADDR_W:0]   cfg_words,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  input  logic              cpu_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              mem_we,
  output logic              handover,
  output logic              load_err
);
  logic              rs1_q, rs2_q, srst_n;
  logic              en_lat, run_en, gclk;
  logic [7:0]        rx_byte, fifo_byte;
  logic              rx_vld, fifo_empty, fifo_pop, ovf;
  logic              ld_we, ld_done;
  logic [ADDR_W-1:0] ld_addr;
  logic [31:0]       ld_wdata;
  logic              ho_q, ho_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  assign run_en = !(ld_done || ovf);

  always_latch begin
    if (!clk) en_lat = run_en;
  end
  assign gclk = clk & en_lat;

  bootld_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_rx (
    .clk(gclk), .rst_n(srst_n), .rxd(rxd), .rx_byte(rx_byte), .rx_vld(rx_vld)
  );

  bootld_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(gclk), .rst_n(srst_n), .push(rx_vld), .din(rx_byte), .pop(fifo_pop),
    .dout(fifo_byte), .empty(fifo_empty), .ovf(ovf)
  );

  bootld_seq #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC), .POP_GAP(POP_GAP)) u_seq (
    .clk(gclk), .rst_n(srst_n), .fifo_empty(fifo_empty), .fifo_byte(fifo_byte),
    .rx_seen(rx_vld), .cfg_words(cfg_words), .fifo_pop(fifo_pop), .wr_en(ld_we),
    .wr_addr(ld_addr), .wr_data(ld_wdata), .done(ld_done)
  );

  assign ho_d = ho_q | (ld_done && !ovf);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ho_q <= 1'b0;
    else         ho_q <= ho_d;
  end

  assign handover  = ho_q;
  assign load_err  = ovf;
  assign mem_we    = ho_q ? cpu_we    : ld_we;
  assign mem_addr  = ho_q ? cpu_addr  : ld_addr;
  assign mem_wdata = ho_q ? cpu_wdata : ld_wdata;

endmodule

// File: rtl/bootld_chk.sv
module bootld_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_we,
  input logic [ADDR_W-1:0] ld_addr,
  input logic              ld_done,
  input logic              handover,
  input logic              load_err
);
  logic [ADDR_W-1:0] exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     exp_q <= '0;
    else if (ld_we) exp_q <= exp_q + 1'b1;
  end

  // R5
  a_r5_seq_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> ld_addr == exp_q);

  // R5
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> !ld_we);

  // R6
  a_r6_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(handover) |-> $past(ld_done) && !ld_we);

  // R8
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    handover |=> handover);

  // R8
  a_r8_no_loader_write: assert property (@(posedge clk) disable iff (!rst_n)
    handover |-> !ld_we);

  // R9
  a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> !handover);

  // R9
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> load_err);

endmodule

bind bootld_top bootld_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
  .ld_done(ld_done), .handover(handover), .load_err(load_err)
);

// File: tb/bootld_top_test.sv
module bootld_top_test;
  localparam int CLK_HZ  = 250_000_000;
  localparam int BAUD    = 3_906_250;
  localparam int BIT     = 64;
  localparam int AW      = 8;
  localparam int TOUT    = 3000;

  logic clk = 1'b0;
  logic rst_n;
  logic rxd, rxd_o;
  logic [AW:0] cfg, cfg_o;
  logic [AW-1:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic cpu_we;
  logic [AW-1:0] mem_addr, mem_addr_o;
  logic [31:0] mem_wdata, mem_wdata_o;
  logic mem_we, mem_we_o, handover, handover_o, load_err, load_err_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bootld_top #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIFO_DEPTH(4), .ADDR_W(AW),
               .TIMEOUT_CYC(TOUT), .POP_GAP(0)) uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_words(cfg), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .handover(handover), .load_err(load_err)
  );

  bootld_top #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIFO_DEPTH(2), .ADDR_W(AW),
               .TIMEOUT_CYC(TOUT), .POP_GAP(4000)) uut_ovf (
    .clk(clk), .rst_n(rst_n), .rxd(rxd_o), .cfg_words(cfg_o), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .mem_addr(mem_addr_o), .mem_wdata(mem_wdata_o),
    .mem_we(mem_we_o), .handover(handover_o), .load_err(load_err_o)
  );

  logic [31:0] cap [256];
  int wr_cnt, ho_we_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt    <= 0;
      ho_we_cnt <= 0;
    end else if (mem_we) begin
      if (handover) ho_we_cnt <= ho_we_cnt + 1;
      else begin
        cap[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  function automatic logic [31:0] pack4(input logic [7:0] b0, b1, b2, b3);
    return {b3, b2, b1, b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input bit sel, input logic [7:0] v);
    logic [9:0] fr;
    fr = {1'b1, v, 1'b0};
    for (int i = 0; i < 10; i++) begin
      if (sel) rxd_o = fr[i]; else rxd = fr[i];
      wait_clk(BIT);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  logic [7:0] bq [16];

  initial begin
    void'($urandom(32'd20240601));
    rxd = 1'b1; rxd_o = 1'b1; cfg = '0; cfg_o = '0;
    cpu_addr = 8'h5A; cpu_wdata = 32'hDEADBEEF; cpu_we = 1'b1;
    do_reset();

    // R1 reset state
    chk("R1 handover", {31'h0, handover}, 32'h0);
    chk("R1 load_err", {31'h0, load_err}, 32'h0);
    chk("R1 mem_we", {31'h0, mem_we}, 32'h0);
    chk("R1 mem_addr", {24'h0, mem_addr}, 32'h0);
    cpu_we = 1'b0; cpu_addr = '0;

    // R3 glitch then directed count-terminated load (R2 R4 R5 R6)
    cfg = 9'd2;
    rxd = 1'b0; wait_clk(16); rxd = 1'b1; wait_clk(300);
    begin
      logic [7:0] d [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 8'h5A, 8'h00, 8'hFF};
      for (int i = 0; i < 8; i++) send_byte(1'b0, d[i]);
    end
    wait_clk(100);
    chk("R3 glitch gives no byte, write count", wr_cnt, 2);
    chk("R4 word0 little-endian", cap[0], 32'h44332211);
    chk("R2 R5 word1 at address 1", cap[1], 32'hFF005AA5);
    chk("R6 handover after count", {31'h0, handover}, 32'h1);

    // R8 pass-through and no loader writes
    cpu_addr = 8'h07; cpu_wdata = 32'h0BADF00D; cpu_we = 1'b1;
    #1;
    chk("R8 mem_we follows cpu", {31'h0, mem_we}, 32'h1);
    chk("R8 mem_addr follows cpu", {24'h0, mem_addr}, 32'h07);
    chk("R8 mem_wdata follows cpu", mem_wdata, 32'h0BADF00D);
    wait_clk(1);
    cpu_we = 1'b0;
    for (int i = 0; i < 4; i++) send_byte(1'b0, 8'h77);
    wait_clk(100);
    chk("R8 bytes after handover write nothing", ho_we_cnt, 1);
    chk("R8 handover sticky", {31'h0, handover}, 32'h1);

    // R7 R10 timeout with partial word
    cpu_addr = '0;
    cfg = '0;
    do_reset();
    wait_clk(4000);
    chk("R7 R10 no timeout before first byte", {31'h0, handover}, 32'h0);
    begin
      logic [7:0] d [6] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'hC3, 8'h3C};
      for (int i = 0; i < 6; i++) send_byte(1'b0, d[i]);
    end
    wait_clk(TOUT / 2);
    chk("R7 still loading inside window", {31'h0, handover}, 32'h0);
    wait_clk(TOUT);
    chk("R7 write count", wr_cnt, 2);
    chk("R7 full word", cap[0], 32'h04030201);
    chk("R7 zero-padded word", cap[1], 32'h00003CC3);
    chk("R7 handover after timeout", {31'h0, handover}, 32'h1);

    // random trials: even count-terminated, odd timeout-terminated
    for (int t = 0; t < 4; t++) begin
      int nb, nw;
      do_reset();
      if (t % 2 == 0) begin
        nw = 1 + int'($urandom % 4);
        nb = nw * 4;
        cfg = 9'(nw);
      end else begin
        nb = 1 + int'($urandom % 15);
        nw = (nb + 3) / 4;
        cfg = '0;
      end
      for (int i = 0; i < 16; i++) bq[i] = (i < nb) ? 8'($urandom) : 8'h00;
      for (int i = 0; i < nb; i++) send_byte(1'b0, bq[i]);
      wait_clk((t % 2 == 0) ? 100 : TOUT + 200);
      chk((t % 2 == 0) ? "R6 random write count" : "R7 random write count", wr_cnt, nw);
      for (int w = 0; w < nw; w++)
        chk("R4 R5 random word", cap[w], pack4(bq[4*w], bq[4*w+1], bq[4*w+2], bq[4*w+3]));
      chk((t % 2 == 0) ? "R6 random handover" : "R7 random handover",
          {31'h0, handover}, 32'h1);
    end

    // R9 overflow on the slow-drain instance
    do_reset();
    for (int i = 0; i < 4; i++) send_byte(1'b1, 8'(8'h90 + i));
    wait_clk(200);
    chk("R9 load_err set", {31'h0, load_err_o}, 32'h1);
    wait_clk(5000);
    chk("R9 handover withheld", {31'h0, handover_o}, 32'h0);
    chk("R9 load_err sticky", {31'h0, load_err_o}, 32'h1);

    finish_run();
  end

endmodule